// File: doc/BRIEF.md
# Pin-Walking Board Test Controller

This block is a test-mode controller for a chip's digital pins, used on a populated board to find pins that are bent, open or shorted. An active-low select input puts the chip into test mode. While the chip is in test mode, the core is held in reset, every digital output and bidirectional pad is released to high impedance, and a second input, which is normally a bus address-enable strobe, becomes the step clock. Each high-to-low transition of the step input moves a pointer forward by one position through two phases.

In the drive phase, exactly one of the 34 output-only and bidirectional pads is driven low at each step, so a zero walks across the pins. In the sense phase, the level on one of the 50 input-only and bidirectional pads is captured at each step and presented on a single observation pad, which is one of the output pads. A tester at the board edge can then compare the walked pattern and the observed bits against what the board should show. The order of the pins in each phase comes from a parameter table. The drive phase takes the pins in one direction and, by default, the sense phase takes them in the other. Analog and oscillator pads are not wired to this block.

All logic runs on the system clock. The select input and the step input are sampled as synchronous inputs.

Top module: `pin_walk_tester`

## Requirements
- R1: While `testN` is high and the block is not in test mode, every `padOutVal`/`padOutEn`/`padBidirVal`/`padBidirEn` bit equals the matching core input, and `coreRstN` is high.
- R2: Test mode is entered at the first clock edge at which `testN` is low after being high, provided `stepIn` is low at that same edge. If `stepIn` is high at that edge, the request is ignored: the pads stay under core control, `coreRstN` stays high and steps have no effect, until `testN` goes high and then low again.
- R3: From the clock edge that enters test mode, `coreRstN` is low, and all pad enables are low until the first step.
- R4: A step occurs only at a clock edge where `stepIn` is low and was high at the previous edge. Holding `stepIn` at either level moves nothing. The pads show the new step right after that edge.
- R5: In test mode, at most one pad enable is high.
- R6: The first step after entry selects drive step 0. Drive step k (0..33) enables combined drive pin `DRIVE_ORDER[k]` with value 0. Combined drive pins 0..16 are `padOut[0..16]` and 17..33 are `padBidir[0..16]`. The default order maps k to k.
- R7: The step after drive step 33 selects sense step 0. At sense step j (0..49) only `padOut[OBS_IDX]` (default 3) is enabled, and it carries the level that combined sense pin `SENSE_ORDER[j]` had at the step's clock edge. Combined sense pins 0..32 are `padIn[0..32]` and 33..49 are `padBidirIn[0..16]`. The default order maps j to 49-j.
- R8: The observed bit holds between steps, even if the observed pin changes.
- R9: The step after sense step 49 returns to drive step 0.
- R10: At the first clock edge where `testN` is high, test mode ends: the pads return to core control and `coreRstN` goes high. After re-entry, the first step is drive step 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testN | input | 1 | Active-low test mode select |
| stepIn | input | 1 | Address-enable strobe, used as the step clock in test mode |
| coreOutVal | input | 17 | Core values for the output-only pads |
| coreOutEn | input | 17 | Core enables for the output-only pads |
| coreBidirVal | input | 17 | Core values for the bidirectional pads |
| coreBidirEn | input | 17 | Core enables for the bidirectional pads |
| padIn | input | 33 | Levels on the input-only pads |
| padBidirIn | input | 17 | Levels on the bidirectional pads |
| padOutVal | output | 17 | Values to the output-only pads |
| padOutEn | output | 17 | Enables to the output-only pads |
| padBidirVal | output | 17 | Values to the bidirectional pads |
| padBidirEn | output | 17 | Enables to the bidirectional pads |
| coreRstN | output | 1 | Active-low reset to the core, held low in test mode |

## Verification
The assertions check the following on every cycle:
- no more than one pad is enabled in test mode;
- a pad driven in the drive phase is always low;
- the observation pad is the only one enabled in the sense phase, and its bit does not change between steps;
- test mode can only be entered while the step input is low, and a high select always ends it;
- the pointer never moves without a step-input fall.

Only the bench scenarios can show the following:
- the actual order of pins walked in both phases, against an independent model;
- the captured levels under several pin patterns;
- the wrap between phases and back to the start;
- a rejected entry request that stays rejected;
- the restart from drive step 0 after re-entry.

// File: rtl/pinwalk_pkg.sv
package pinwalk_pkg;

  // Upper bound on pins per phase; sets the index width
  localparam int MAX_PINS = 64;

  typedef logic [5:0] pinIdx_t;
  typedef pinIdx_t [MAX_PINS-1:0] orderTable_t;

  typedef enum logic {
    PH_DRIVE = 1'b0,
    PH_SENSE = 1'b1
  } phase_t;

  // Strobes from the sequencer to the pad datapath
  typedef struct packed {
    logic    testMode;
    logic    driveOn;
    logic    senseOn;
    pinIdx_t stepIdx;
    logic    capture;
    pinIdx_t captureIdx;
  } walkStrobe_t;

  // Build a linear order table: ascending 0..count-1 or descending count-1..0
  function automatic orderTable_t rampOrder(int count, bit descending);
    orderTable_t t;
    t = '0;
    for (int i = 0; i < MAX_PINS; i++) begin
      if (i < count) t[i] = descending ? pinIdx_t'(count - 1 - i) : pinIdx_t'(i);
    end
    return t;
  endfunction

endpackage

// File: rtl/pinwalk_ctrl.sv
module pinwalk_ctrl
  import pinwalk_pkg::*;
#(
  parameter int NUM_DRIVE = 34,
  parameter int NUM_SENSE = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        testN,
  input  logic        stepIn,
  output walkStrobe_t strobe
);

  localparam pinIdx_t LAST_DRIVE = pinIdx_t'(NUM_DRIVE - 1);
  localparam pinIdx_t LAST_SENSE = pinIdx_t'(NUM_SENSE - 1);

  logic    testNPrev;
  logic    stepPrev;
  logic    testMode;
  logic    started;
  phase_t  phase;
  pinIdx_t idx;

  logic    stepFall;
  logic    enterReq;
  phase_t  nextPhase;
  pinIdx_t nextIdx;

  assign stepFall = testMode && !testN && stepPrev && !stepIn;
  assign enterReq = !testMode && testNPrev && !testN && !stepIn;

  // Successor of the current position; the first step lands on drive step 0
  always_comb begin
    nextPhase = PH_DRIVE;
    nextIdx   = '0;
    if (started) begin
      if (phase == PH_DRIVE) begin
        if (idx == LAST_DRIVE) begin
          nextPhase = PH_SENSE;
        end else begin
          nextIdx = idx + 1'b1;
        end
      end else begin
        if (idx != LAST_SENSE) begin
          nextPhase = PH_SENSE;
          nextIdx   = idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testNPrev <= 1'b1;
      stepPrev  <= 1'b0;
      testMode  <= 1'b0;
      started   <= 1'b0;
      phase     <= PH_DRIVE;
      idx       <= '0;
    end else begin
      testNPrev <= testN;
      stepPrev  <= stepIn;
      if (testN) begin
        testMode <= 1'b0;
        started  <= 1'b0;
        phase    <= PH_DRIVE;
        idx      <= '0;
      end else if (enterReq) begin
        testMode <= 1'b1;
      end else if (stepFall) begin
        started <= 1'b1;
        phase   <= nextPhase;
        idx     <= nextIdx;
      end
    end
  end

  always_comb begin
    strobe.testMode   = testMode;
    strobe.driveOn    = testMode && started && (phase == PH_DRIVE);
    strobe.senseOn    = testMode && started && (phase == PH_SENSE);
    strobe.stepIdx    = idx;
    strobe.capture    = stepFall && (nextPhase == PH_SENSE);
    strobe.captureIdx = nextIdx;
  end

  AST_ENTRY_STEP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testMode) |-> $past(!stepIn && testNPrev && !testN)); // R2
  AST_EXIT_ON_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    testN |=> !testMode); // R10
  AST_HOLD_WITHOUT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !testN && !(stepPrev && !stepIn)) |=> ($stable(idx) && $stable(phase))); // R4
  AST_DRIVE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DRIVE) |-> (idx <= LAST_DRIVE)); // R6

endmodule

// File: rtl/pinwalk_datapath.sv
module pinwalk_datapath
  import pinwalk_pkg::*;
#(
  parameter int          NUM_OUT     = 17,
  parameter int          NUM_BIDIR   = 17,
  parameter int          NUM_IN      = 33,
  parameter int          OBS_IDX     = 3,
  parameter orderTable_t DRIVE_ORDER = rampOrder(NUM_OUT + NUM_BIDIR, 1'b0),
  parameter orderTable_t SENSE_ORDER = rampOrder(NUM_IN + NUM_BIDIR, 1'b1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  walkStrobe_t          strobe,
  input  logic [NUM_OUT-1:0]   coreOutVal,
  input  logic [NUM_OUT-1:0]   coreOutEn,
  input  logic [NUM_BIDIR-1:0] coreBidirVal,
  input  logic [NUM_BIDIR-1:0] coreBidirEn,
  input  logic [NUM_IN-1:0]    padIn,
  input  logic [NUM_BIDIR-1:0] padBidirIn,
  output logic [NUM_OUT-1:0]   padOutVal,
  output logic [NUM_OUT-1:0]   padOutEn,
  output logic [NUM_BIDIR-1:0] padBidirVal,
  output logic [NUM_BIDIR-1:0] padBidirEn
);

  localparam int NUM_DRIVE = NUM_OUT + NUM_BIDIR;
  localparam int NUM_SENSE = NUM_IN + NUM_BIDIR;
  localparam logic [NUM_OUT-1:0] OBS_MASK = NUM_OUT'(1) << OBS_IDX;

  logic [NUM_DRIVE-1:0] driveSel;
  logic [NUM_SENSE-1:0] senseVec;
  logic                 senseLevel;
  logic                 obsBit;

  assign senseVec = {padBidirIn, padIn};

  // Level of the pin that the next sense step selects
  always_comb begin
    senseLevel = 1'b0;
    for (int k = 0; k < NUM_SENSE; k++) begin
      if (SENSE_ORDER[strobe.captureIdx] == pinIdx_t'(k)) senseLevel = senseVec[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obsBit <= 1'b0;
    end else if (!strobe.testMode) begin
      obsBit <= 1'b0;
    end else if (strobe.capture) begin
      obsBit <= senseLevel;
    end
  end

  for (genvar g = 0; g < NUM_DRIVE; g++) begin : gDriveSel
    assign driveSel[g] = strobe.driveOn && (DRIVE_ORDER[strobe.stepIdx] == pinIdx_t'(g));
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : gOutPad
    if (g == OBS_IDX) begin : gObs
      assign padOutEn[g]  = strobe.testMode ? (driveSel[g] | strobe.senseOn) : coreOutEn[g];
      assign padOutVal[g] = strobe.testMode ? (strobe.senseOn & obsBit) : coreOutVal[g];
    end else begin : gPlain
      assign padOutEn[g]  = strobe.testMode ? driveSel[g] : coreOutEn[g];
      assign padOutVal[g] = strobe.testMode ? 1'b0 : coreOutVal[g];
    end
  end

  for (genvar g = 0; g < NUM_BIDIR; g++) begin : gBidirPad
    assign padBidirEn[g]  = strobe.testMode ? driveSel[NUM_OUT + g] : coreBidirEn[g];
    assign padBidirVal[g] = strobe.testMode ? 1'b0 : coreBidirVal[g];
  end

  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.testMode |-> ($countones({padOutEn, padBidirEn}) <= 1)); // R5
  AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.driveOn |-> (((padOutVal & padOutEn) == '0) && ((padBidirVal & padBidirEn) == '0))); // R6
  AST_SENSE_ONLY_OBS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.senseOn |-> ((padOutEn == OBS_MASK) && (padBidirEn == '0))); // R7
  AST_OBS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.senseOn && !strobe.capture) |=> (!strobe.senseOn || $stable(padOutVal[OBS_IDX]))); // R8

endmodule

// File: rtl/pin_walk_tester.sv
module pin_walk_tester
  import pinwalk_pkg::*;
#(
  parameter int          NUM_OUT     = 17,
  parameter int          NUM_BIDIR   = 17,
  parameter int          NUM_IN      = 33,
  parameter int          OBS_IDX     = 3,
  parameter orderTable_t DRIVE_ORDER = rampOrder(NUM_OUT + NUM_BIDIR, 1'b0),
  parameter orderTable_t SENSE_ORDER = rampOrder(NUM_IN + NUM_BIDIR, 1'b1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 testN,
  input  logic                 stepIn,
  input  logic [NUM_OUT-1:0]   coreOutVal,
  input  logic [NUM_OUT-1:0]   coreOutEn,
  input  logic [NUM_BIDIR-1:0] coreBidirVal,
  input  logic [NUM_BIDIR-1:0] coreBidirEn,
  input  logic [NUM_IN-1:0]    padIn,
  input  logic [NUM_BIDIR-1:0] padBidirIn,
  output logic [NUM_OUT-1:0]   padOutVal,
  output logic [NUM_OUT-1:0]   padOutEn,
  output logic [NUM_BIDIR-1:0] padBidirVal,
  output logic [NUM_BIDIR-1:0] padBidirEn,
  output logic                 coreRstN
);

  localparam int NUM_DRIVE = NUM_OUT + NUM_BIDIR;
  localparam int NUM_SENSE = NUM_IN + NUM_BIDIR;

  walkStrobe_t strobe;

  pinwalk_ctrl #(
    .NUM_DRIVE(NUM_DRIVE),
    .NUM_SENSE(NUM_SENSE)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .testN  (testN),
    .stepIn (stepIn),
    .strobe (strobe)
  );

  pinwalk_datapath #(
    .NUM_OUT    (NUM_OUT),
    .NUM_BIDIR  (NUM_BIDIR),
    .NUM_IN     (NUM_IN),
    .OBS_IDX    (OBS_IDX),
    .DRIVE_ORDER(DRIVE_ORDER),
    .SENSE_ORDER(SENSE_ORDER)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .coreOutVal  (coreOutVal),
    .coreOutEn   (coreOutEn),
    .coreBidirVal(coreBidirVal),
    .coreBidirEn (coreBidirEn),
    .padIn       (padIn),
    .padBidirIn  (padBidirIn),
    .padOutVal   (padOutVal),
    .padOutEn    (padOutEn),
    .padBidirVal (padBidirVal),
    .padBidirEn  (padBidirEn)
  );

  assign coreRstN = ~strobe.testMode;

endmodule

// File: tb/pin_walk_tester_test.sv
module pin_walk_tester_test;

  localparam int NO  = 17;
  localparam int NB  = 17;
  localparam int NI  = 33;
  localparam int OBS = 3;
  localparam int ND  = NO + NB;
  localparam int NS  = NI + NB;

  localparam logic [49:0] PATS [4] = '{
    50'h0000000000000,
    50'h3FFFFFFFFFFFF,
    50'h2AAAAAAAAAAAA,
    50'h1234567890ABC
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN, testN, stepIn;
  logic [NO-1:0] coreOutVal, coreOutEn;
  logic [NB-1:0] coreBidirVal, coreBidirEn;
  logic [NI-1:0] padIn;
  logic [NB-1:0] padBidirIn;
  logic [NO-1:0] padOutVal, padOutEn;
  logic [NB-1:0] padBidirVal, padBidirEn;
  logic          coreRstN;

  int vecs = 0;
  int errs = 0;

  pin_walk_tester uut (
    .clk(clk), .rstN(rstN), .testN(testN), .stepIn(stepIn),
    .coreOutVal(coreOutVal), .coreOutEn(coreOutEn),
    .coreBidirVal(coreBidirVal), .coreBidirEn(coreBidirEn),
    .padIn(padIn), .padBidirIn(padBidirIn),
    .padOutVal(padOutVal), .padOutEn(padOutEn),
    .padBidirVal(padBidirVal), .padBidirEn(padBidirEn),
    .coreRstN(coreRstN)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkPassthrough(input string req);
    check(req, {30'd0, padBidirEn, padOutEn}, {30'd0, coreBidirEn, coreOutEn});
    check(req, {30'd0, padBidirVal, padOutVal}, {30'd0, coreBidirVal, coreOutVal});
    check(req, {63'd0, coreRstN}, 64'd1);
  endtask

  task automatic fallStep();
    @(negedge clk) stepIn = 1'b1;
    @(negedge clk) stepIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkDrive(input string req, input int k);
    check(req, {30'd0, padBidirEn, padOutEn}, 64'd1 << k);
    check(req, {30'd0, padBidirVal & padBidirEn, padOutVal & padOutEn}, 64'd0);
  endtask

  task automatic checkSense(input string req, input int j);
    logic [49:0] lv;
    int sel;
    lv  = {padBidirIn, padIn};
    sel = NS - 1 - j;
    check(req, {30'd0, padBidirEn, padOutEn}, 64'd1 << OBS);
    check(req, {63'd0, padOutVal[OBS]}, {63'd0, lv[sel]});
  endtask

  initial begin
    #500000;
    errs++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rstN = 1'b0; testN = 1'b1; stepIn = 1'b0;
    coreOutVal = 17'h1A5A5; coreOutEn = 17'h0F0F3;
    coreBidirVal = 17'h15555; coreBidirEn = 17'h0AAAA;
    {padBidirIn, padIn} = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkPassthrough("R1 reset/normal");

    // R2: rejected request because stepIn is high when testN falls
    stepIn = 1'b1; testN = 1'b0;
    repeat (2) @(negedge clk);
    stepIn = 1'b0;
    repeat (2) @(negedge clk);
    checkPassthrough("R2 rejected entry");
    fallStep();
    checkPassthrough("R2 step ignored outside test");

    // Leave, then enter properly
    testN = 1'b1;
    @(negedge clk);
    testN = 1'b0;
    @(negedge clk);
    check("R3 core reset", {63'd0, coreRstN}, 64'd0);
    check("R3 all tristate", {30'd0, padBidirEn, padOutEn}, 64'd0);

    // R4: holding stepIn high advances nothing
    stepIn = 1'b1;
    repeat (5) @(negedge clk);
    check("R4 held high", {30'd0, padBidirEn, padOutEn}, 64'd0);
    stepIn = 1'b0;
    @(negedge clk);
    checkDrive("R6 first step", 0);
    repeat (4) @(negedge clk);
    checkDrive("R4 held low", 0);
    fallStep();
    fallStep();
    checkDrive("R6 step two", 2);

    // R10: exit and re-entry
    testN = 1'b1;
    @(negedge clk);
    checkPassthrough("R10 exit");
    testN = 1'b0;
    @(negedge clk);
    check("R10 reentered", {63'd0, coreRstN}, 64'd0);

    // Vector table: full walks under each pad pattern, wrapping between rounds
    for (int p = 0; p < 4; p++) begin
      {padBidirIn, padIn} = PATS[p];
      for (int s = 0; s < ND + NS; s++) begin
        fallStep();
        if (s < ND) checkDrive((s == 0 && p > 0) ? "R9 wrap" : (s == 0 ? "R10 restart" : "R6 drive"), s);
        else checkSense("R7 sense", s - ND);
        check("R3 core reset held", {63'd0, coreRstN}, 64'd0);
      end
    end

    // R8: observed bit holds when the pin changes after capture
    for (int s = 0; s < ND; s++) fallStep();
    padBidirIn = '0;
    padBidirIn[NB-1] = 1'b1;
    fallStep();
    check("R8 captured", {63'd0, padOutVal[OBS]}, 64'd1);
    padBidirIn[NB-1] = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 held", {63'd0, padOutVal[OBS]}, 64'd1);
    fallStep();
    checkSense("R7 next sense", 1);

    testN = 1'b1;
    @(negedge clk);
    checkPassthrough("R10 final exit");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule